// File: doc/BRIEF.md
# Comparator Output Conditioner

The block takes the raw one-bit result of an analog comparator and makes it fit for control logic. The bit passes through four stages in order. An optional two-flop synchronizer comes first. An optional inverter follows. Next is an edge-triggered blanking stage: for a programmed number of cycles it freezes the level at the value it had before the blanking trigger. Last is a stability filter. The filter lets a new level through only after that level has been present for a chosen number of consecutive cycles.

The filter can be limited to the periods when one particular reference, as shown by a select input, drives the converter. When the filter is gated off, the level passes straight through. The conditioned level drives `cmpOut`. The block also gives one-cycle pulses on each rising and each falling transition of that output.

The blanking trigger is the external `blankTrig` pin when external blanking is enabled. Otherwise it is the block's own post-inversion level. The chosen edge polarity of that source starts or restarts the blanking window.

Top module: `cmp_blank_filter`

## Requirements
- R1: While `rst_n` is low and after reset is released, `cmpOut`, `riseEvt` and `fallEvt` are low, until a high conditioned level reaches the output.
- R2: With `cfgSyncEn`=0, a change on `cmpRaw` reaches `cmpOut` at the next clock edge (filter and blanking off). With `cfgSyncEn`=1, it reaches `cmpOut` at the third clock edge.
- R3: With `cfgInvEn`=1, the level entering the blanking stage is the complement of the (optionally synchronized) raw bit.
- R4: `cfgBlankMode` selects the edge of the blanking source that triggers blanking: 0 none, 1 rising, 2 falling, 3 both. The source is `blankTrig` when `cfgExtBlank`=1, and the post-inversion level otherwise.
- R5: A trigger masks the trigger cycle and the following cycles, `cfgBlankLen` clock edges in total. During that time the blanking stage holds the last level seen before the window. A length of 0 disables blanking.
- R6: A trigger that arrives inside an active window restarts the full count of `cfgBlankLen` edges from that trigger.
- R7: With the filter active, a new level is taken only at the N-th consecutive edge on which it differs from `cmpOut`. N is `cfgFiltCode`+2 for codes 0 to 14 and 32 for code 15. A shorter run is discarded.
- R8: `cfgFiltGate` 0 or 3 filters whenever `cfgFiltEn`=1. Value 1 filters only while `refSel`=0 (reference 1 active). Value 2 filters only while `refSel`=1 (reference 2 active). When the filter is gated off or disabled, the blanked level is copied to `cmpOut` at each edge.
- R9: `riseEvt` is high for exactly the first cycle in which `cmpOut` is high after being low. `fallEvt` is high for exactly the first cycle in which `cmpOut` is low after being high. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpRaw | input | 1 | Raw comparator result |
| blankTrig | input | 1 | External blanking trigger |
| refSel | input | 1 | Active reference: 0 reference 1, 1 reference 2 |
| cfgSyncEn | input | 1 | Enable the two-flop synchronizer |
| cfgInvEn | input | 1 | Invert the comparator level |
| cfgBlankMode | input | 2 | Blanking edge: 0 off, 1 rise, 2 fall, 3 both |
| cfgExtBlank | input | 1 | Use `blankTrig` as the blanking source |
| cfgBlankLen | input | BLANK_W (7) | Blanking length in clock edges |
| cfgFiltEn | input | 1 | Enable the stability filter |
| cfgFiltCode | input | CODE_W (4) | Filter length code |
| cfgFiltGate | input | 2 | Filter gating by active reference |
| cmpOut | output | 1 | Conditioned comparator level |
| riseEvt | output | 1 | One-cycle pulse on a rising output transition |
| fallEvt | output | 1 | One-cycle pulse on a falling output transition |

## Verification
The assertions check the following on every cycle. The edge pulses always agree with the output's transitions and never coincide. An unfiltered output stays frozen while blanking is active. A zero blanking length never opens a window. The decoded filter length stays between 2 and 32. The filter is off whenever gating excludes the current reference. The exact filter lengths per code, the restart of a window by a second trigger, and the sync latency can only be shown by the bench scenarios. These scenarios compare a behavioural model against the outputs on every cycle and also use directed cycle counts.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int FILT_LEN_W = 6;

  typedef enum logic [1:0] {
    BLANK_OFF  = 2'd0,
    BLANK_RISE = 2'd1,
    BLANK_FALL = 2'd2,
    BLANK_BOTH = 2'd3
  } blankMode_e;

  typedef enum logic [1:0] {
    GATE_ALWAYS  = 2'd0,
    GATE_REF1    = 2'd1,
    GATE_REF2    = 2'd2,
    GATE_ALWAYS2 = 2'd3
  } filtGate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  blankNow;
    logic                  filtOn;
    logic [FILT_LEN_W-1:0] filtLen;
  } condStrb_t;
endpackage

// File: rtl/cmp_cond_ctrl.sv
module cmp_cond_ctrl
  import cmp_cond_pkg::*;
#(
  parameter int BLANK_W  = 7,
  parameter int CODE_W   = 4,
  parameter int LONG_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl,
  input  logic               blankTrig,
  input  logic               refSel,
  input  logic [1:0]         cfgBlankMode,
  input  logic               cfgExtBlank,
  input  logic [BLANK_W-1:0] cfgBlankLen,
  input  logic               cfgFiltEn,
  input  logic [CODE_W-1:0]  cfgFiltCode,
  input  logic [1:0]         cfgFiltGate,
  output condStrb_t          strb
);
  localparam int PAD_W = FILT_LEN_W - CODE_W;

  logic               srcNow;
  logic               srcPrev;
  logic               srcRise;
  logic               srcFall;
  logic               trigHit;
  logic               armWin;
  logic [BLANK_W-1:0] blankLeft;
  logic               gateOk;

  // blanking source and edge qualification
  assign srcNow  = cfgExtBlank ? blankTrig : lvl;
  assign srcRise = srcNow & ~srcPrev;
  assign srcFall = ~srcNow & srcPrev;

  always_comb begin
    unique case (blankMode_e'(cfgBlankMode))
      BLANK_RISE: trigHit = srcRise;
      BLANK_FALL: trigHit = srcFall;
      BLANK_BOTH: trigHit = srcRise | srcFall;
      default:    trigHit = 1'b0;
    endcase
  end

  assign armWin = trigHit && (cfgBlankLen != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcPrev   <= 1'b0;
      blankLeft <= '0;
    end else begin
      srcPrev <= srcNow;
      if (armWin)
        blankLeft <= cfgBlankLen - BLANK_W'(1);
      else if (blankLeft != '0)
        blankLeft <= blankLeft - BLANK_W'(1);
    end
  end

  // filter gating by active reference
  always_comb begin
    unique case (filtGate_e'(cfgFiltGate))
      GATE_REF1: gateOk = ~refSel;
      GATE_REF2: gateOk = refSel;
      default:   gateOk = 1'b1;
    endcase
  end

  assign strb.blankNow = armWin || (blankLeft != '0);
  assign strb.filtOn   = cfgFiltEn & gateOk;
  assign strb.filtLen  = (cfgFiltCode == '1) ? FILT_LEN_W'(LONG_LEN)
                       : ({{PAD_W{1'b0}}, cfgFiltCode} + FILT_LEN_W'(2));
endmodule

// File: rtl/cmp_cond_dp.sv
module cmp_cond_dp
  import cmp_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmpRaw,
  input  logic      cfgSyncEn,
  input  logic      cfgInvEn,
  input  condStrb_t strb,
  output logic      lvl,
  output logic      cmpOut,
  output logic      riseEvt,
  output logic      fallEvt
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   heldQ;
  logic                   bLvl;
  logic                   outQ;
  logic                   outNext;
  logic [FILT_LEN_W-1:0]  runQ;
  logic [FILT_LEN_W-1:0]  runD;
  logic [FILT_LEN_W-1:0]  runNext;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= cmpRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], cmpRaw};
      end
    end
  endgenerate

  assign syncOut = cfgSyncEn ? syncQ[SYNC_STAGES-1] : cmpRaw;
  assign lvl     = syncOut ^ cfgInvEn;

  // blanking hold
  always_ff @(posedge clk) begin
    if (!rst_n)             heldQ <= 1'b0;
    else if (!strb.blankNow) heldQ <= lvl;
  end
  assign bLvl = strb.blankNow ? heldQ : lvl;

  // stability filter
  assign runNext = runQ + FILT_LEN_W'(1);
  always_comb begin
    outNext = outQ;
    runD    = runQ;
    if (!strb.filtOn) begin
      outNext = bLvl;
      runD    = '0;
    end else if (bLvl == outQ) begin
      runD = '0;
    end else if (runNext >= strb.filtLen) begin
      outNext = bLvl;
      runD    = '0;
    end else begin
      runD = runNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outQ    <= 1'b0;
      runQ    <= '0;
      riseEvt <= 1'b0;
      fallEvt <= 1'b0;
    end else begin
      outQ    <= outNext;
      runQ    <= runD;
      riseEvt <= outNext & ~outQ;
      fallEvt <= ~outNext & outQ;
    end
  end

  assign cmpOut = outQ;
endmodule

// File: rtl/cmp_blank_filter.sv
module cmp_blank_filter
  import cmp_cond_pkg::*;
#(
  parameter int BLANK_W     = 7,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_LEN    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmpRaw,
  input  logic               blankTrig,
  input  logic               refSel,
  input  logic               cfgSyncEn,
  input  logic               cfgInvEn,
  input  logic [1:0]         cfgBlankMode,
  input  logic               cfgExtBlank,
  input  logic [BLANK_W-1:0] cfgBlankLen,
  input  logic               cfgFiltEn,
  input  logic [CODE_W-1:0]  cfgFiltCode,
  input  logic [1:0]         cfgFiltGate,
  output logic               cmpOut,
  output logic               riseEvt,
  output logic               fallEvt
);
  condStrb_t strb;
  logic      lvl;

  cmp_cond_ctrl #(
    .BLANK_W (BLANK_W),
    .CODE_W  (CODE_W),
    .LONG_LEN(LONG_LEN)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl         (lvl),
    .blankTrig   (blankTrig),
    .refSel      (refSel),
    .cfgBlankMode(cfgBlankMode),
    .cfgExtBlank (cfgExtBlank),
    .cfgBlankLen (cfgBlankLen),
    .cfgFiltEn   (cfgFiltEn),
    .cfgFiltCode (cfgFiltCode),
    .cfgFiltGate (cfgFiltGate),
    .strb        (strb)
  );

  cmp_cond_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmpRaw   (cmpRaw),
    .cfgSyncEn(cfgSyncEn),
    .cfgInvEn (cfgInvEn),
    .strb     (strb),
    .lvl      (lvl),
    .cmpOut   (cmpOut),
    .riseEvt  (riseEvt),
    .fallEvt  (fallEvt)
  );
endmodule

// File: rtl/cmp_blank_filter_chk.sv
module cmp_blank_filter_chk
  import cmp_cond_pkg::*;
#(
  parameter int BLANK_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               refSel,
  input logic [BLANK_W-1:0] cfgBlankLen,
  input logic               cfgFiltEn,
  input logic [1:0]         cfgFiltGate,
  input logic               cmpOut,
  input logic               riseEvt,
  input logic               fallEvt,
  input condStrb_t          strb
);
  a_r9_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    riseEvt == (cmpOut && !$past(cmpOut)));

  a_r9_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fallEvt == (!cmpOut && $past(cmpOut)));

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(riseEvt && fallEvt));

  a_r5_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.blankNow && !cfgFiltEn && $stable(cfgFiltEn)) |=> $stable(cmpOut));

  a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgBlankLen == '0 && !strb.blankNow) |=> (cfgBlankLen != '0 || !strb.blankNow));

  a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.filtLen >= FILT_LEN_W'(2)) && (strb.filtLen <= FILT_LEN_W'(32)));

  a_r8_gate_ref1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgFiltGate == 2'd1 && refSel) |-> !strb.filtOn);

  a_r8_gate_ref2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgFiltGate == 2'd2 && !refSel) |-> !strb.filtOn);
endmodule

bind cmp_blank_filter cmp_blank_filter_chk #(.BLANK_W(BLANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .refSel     (refSel),
  .cfgBlankLen(cfgBlankLen),
  .cfgFiltEn  (cfgFiltEn),
  .cfgFiltGate(cfgFiltGate),
  .cmpOut     (cmpOut),
  .riseEvt    (riseEvt),
  .fallEvt    (fallEvt),
  .strb       (strb)
);

// File: tb/sim_cmp_blank_filter.sv
module sim_cmp_blank_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmpRaw = 1'b0, blankTrig = 1'b0, refSel = 1'b0;
  logic       cfgSyncEn = 1'b0, cfgInvEn = 1'b0, cfgExtBlank = 1'b0, cfgFiltEn = 1'b0;
  logic [1:0] cfgBlankMode = 2'd0, cfgFiltGate = 2'd0;
  logic [6:0] cfgBlankLen = 7'd0;
  logic [3:0] cfgFiltCode = 4'd0;
  logic       cmpOut, riseEvt, fallEvt;

  int    total = 0, bad = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  cmp_blank_filter u0 (
    .clk(clk), .rst_n(rst_n), .cmpRaw(cmpRaw), .blankTrig(blankTrig), .refSel(refSel),
    .cfgSyncEn(cfgSyncEn), .cfgInvEn(cfgInvEn), .cfgBlankMode(cfgBlankMode),
    .cfgExtBlank(cfgExtBlank), .cfgBlankLen(cfgBlankLen), .cfgFiltEn(cfgFiltEn),
    .cfgFiltCode(cfgFiltCode), .cfgFiltGate(cfgFiltGate),
    .cmpOut(cmpOut), .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  // behavioural reference model
  int rawHist[$];
  int mPrevSrc, mLeft, mHeld, mOut, mRise, mFall, mRun;
  int lvlM, srcM, trgM, blkM, bvM, needM, actM, nxtM;

  always @(posedge clk) begin
    if (!rst_n) begin
      rawHist = {0, 0};
      mPrevSrc = 0; mLeft = 0; mHeld = 0; mOut = 0; mRise = 0; mFall = 0; mRun = 0;
    end else begin
      lvlM = (cfgSyncEn ? rawHist[0] : int'(cmpRaw)) ^ int'(cfgInvEn);
      rawHist.push_back(int'(cmpRaw));
      void'(rawHist.pop_front());
      srcM = cfgExtBlank ? int'(blankTrig) : lvlM;
      trgM = ((cfgBlankMode[0] && srcM == 1 && mPrevSrc == 0) ||
              (cfgBlankMode[1] && srcM == 0 && mPrevSrc == 1)) ? 1 : 0;
      mPrevSrc = srcM;
      blkM = ((trgM == 1 && cfgBlankLen != 0) || mLeft > 0) ? 1 : 0;
      if (trgM == 1 && cfgBlankLen != 0) mLeft = int'(cfgBlankLen) - 1;
      else if (mLeft > 0) mLeft = mLeft - 1;
      bvM = blkM ? mHeld : lvlM;
      if (!blkM) mHeld = lvlM;
      needM = (cfgFiltCode == 4'd15) ? 32 : int'(cfgFiltCode) + 2;
      actM = cfgFiltEn && ((cfgFiltGate == 2'd1) ? !refSel :
                           (cfgFiltGate == 2'd2) ? refSel : 1'b1);
      nxtM = mOut;
      if (!actM) begin nxtM = bvM; mRun = 0; end
      else if (bvM == mOut) mRun = 0;
      else begin
        mRun = mRun + 1;
        if (mRun >= needM) begin nxtM = bvM; mRun = 0; end
      end
      mRise = (nxtM == 1 && mOut == 0) ? 1 : 0;
      mFall = (nxtM == 0 && mOut == 1) ? 1 : 0;
      mOut = nxtM;
    end
  end

  task automatic chk(int act, int exp, string req, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done)
      chk({29'd0, cmpOut, riseEvt, fallEvt}, (mOut << 2) | (mRise << 1) | mFall, curReq, "model {out,rise,fall}");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    cfgSyncEn = 0; cfgInvEn = 0; cfgBlankMode = 0; cfgExtBlank = 0;
    cfgBlankLen = 0; cfgFiltEn = 0; cfgFiltGate = 0; blankTrig = 0; refSel = 0;
  endtask

  task automatic filtLenCheck(logic [3:0] code, int expN);
    quiet(); cfgFiltEn = 1; cfgFiltCode = code;
    cmpRaw = 0; cyc(40);
    cmpRaw = 1;
    for (int k = 1; k <= 40; k++) begin
      cyc(1);
      if (cmpOut) begin chk(k, expN, "R7", "filter edges to pass"); break; end
      if (k == 40) chk(k, expN, "R7", "filter never passed");
    end
  endtask

  initial begin
    cyc(2);
    chk(cmpOut, 0, "R1", "cmpOut in reset");
    chk(riseEvt | fallEvt, 0, "R1", "events in reset");
    cyc(1); rst_n = 1; cyc(2);
    chk(cmpOut, 0, "R1", "cmpOut after reset");

    // R2 latency
    curReq = "R2";
    cmpRaw = 1; cyc(1); chk(cmpOut, 1, "R2", "no-sync latency 1");
    cmpRaw = 0; cyc(2);
    cfgSyncEn = 1; cyc(3);
    cmpRaw = 1; cyc(2); chk(cmpOut, 0, "R2", "sync edge 2");
    cyc(1); chk(cmpOut, 1, "R2", "sync edge 3");
    for (int i = 0; i < 40; i++) begin cmpRaw = (i % 3) == 0; cyc(1); end

    // R3 inversion
    curReq = "R3";
    quiet(); cmpRaw = 0; cfgInvEn = 1; cyc(1);
    chk(cmpOut, 1, "R3", "inverted low");
    for (int i = 0; i < 30; i++) begin cmpRaw = (i % 4) < 2; cyc(1); end
    cfgInvEn = 0; cyc(2);

    // R5 explicit external blanking hold
    curReq = "R5";
    quiet(); cfgExtBlank = 1; cfgBlankMode = 1; cfgBlankLen = 5;
    cmpRaw = 1; cyc(3);
    cmpRaw = 0; blankTrig = 1; cyc(1); blankTrig = 0;
    cyc(4); chk(cmpOut, 1, "R5", "held during window");
    cyc(1); chk(cmpOut, 0, "R5", "released after window");

    // R6 retrigger restarts
    curReq = "R6";
    cmpRaw = 1; cyc(3);
    cmpRaw = 0; blankTrig = 1; cyc(1); blankTrig = 0; cyc(2);
    blankTrig = 1; cyc(1); blankTrig = 0;
    cyc(4); chk(cmpOut, 1, "R6", "held after retrigger");
    cyc(1); chk(cmpOut, 0, "R6", "released after restarted window");

    // R4 edge modes, external and internal sources
    curReq = "R4";
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        quiet(); cfgBlankMode = m[1:0]; cfgExtBlank = e[0]; cfgBlankLen = 7'(3 + m);
        for (int i = 0; i < 60; i++) begin
          cmpRaw = ((i * 7) % 5) < 2;
          blankTrig = (i % 9) < 3;
          cyc(1);
        end
      end
    end
    curReq = "R5";
    quiet(); cfgBlankMode = 3; cfgExtBlank = 1; cfgBlankLen = 0;
    for (int i = 0; i < 30; i++) begin cmpRaw = i[1]; blankTrig = i[0]; cyc(1); end

    // R7 filter lengths
    filtLenCheck(4'd0, 2);
    filtLenCheck(4'd3, 5);
    filtLenCheck(4'd7, 9);
    filtLenCheck(4'd13, 15);
    filtLenCheck(4'd15, 32);
    curReq = "R7";
    for (int c = 0; c < 16; c++) begin
      quiet(); cfgFiltEn = 1; cfgFiltCode = c[3:0];
      for (int i = 0; i < 80; i++) begin cmpRaw = ((i / (c + 1)) % 2) == 1; cyc(1); end
    end

    // R8 gating by reference
    curReq = "R8";
    for (int g = 0; g < 4; g++) begin
      quiet(); cfgFiltEn = 1; cfgFiltCode = 4'd4; cfgFiltGate = g[1:0];
      for (int i = 0; i < 90; i++) begin
        refSel = (i / 30) == 1;
        cmpRaw = (i % 7) < 3;
        cyc(1);
      end
    end
    quiet(); cfgFiltEn = 1; cfgFiltCode = 4'd10; cfgFiltGate = 2'd2; refSel = 0;
    cmpRaw = 0; cyc(3); cmpRaw = 1; cyc(1);
    chk(cmpOut, 1, "R8", "gated off passes directly");

    // R9 randomized mix
    curReq = "R9";
    for (int b = 0; b < 30; b++) begin
      cfgSyncEn = 1'($urandom); cfgInvEn = 1'($urandom);
      cfgBlankMode = 2'($urandom); cfgExtBlank = 1'($urandom);
      cfgBlankLen = 7'($urandom % 12); cfgFiltEn = 1'($urandom);
      cfgFiltCode = 4'($urandom); cfgFiltGate = 2'($urandom);
      for (int i = 0; i < 200; i++) begin
        if (($urandom % 6) == 0) cmpRaw = ~cmpRaw;
        blankTrig = ($urandom % 10) == 0;
        if (($urandom % 50) == 0) refSel = ~refSel;
        cyc(1);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule